// File: doc/BRIEF.md
# Majority-Vote Serial Receiver

This block receives asynchronous serial characters from a single line. The line is first passed through a synchronizer. An external tick at sixteen times the bit rate then divides every bit into sixteen tick slots, numbered 0 to 15. Each bit is sampled on ticks 7, 8 and 9, and the bit takes the value held by at least two of the three samples. When the three samples do not all agree, the frame is marked as noisy. This applies to an accepted start bit, to any data bit and to the stop bit. The receiver then hands the finished character to a holding register and raises a one-cycle receive-full strobe. The noise, framing and break flags are updated in that same cycle.

A controlling state machine works through the following states. `ST_HUNT` watches the line on every tick. A low line moves it to `ST_START`, which raises the receiver-active output. The tick slot that sees the low line is slot 0. At tick 10 of the start bit the vote is read. A high vote is a false start, and the receiver goes back to `ST_HUNT` with receiver-active low. A low vote moves it to `ST_DATA`. `ST_DATA` gathers 8 or 9 data bits, least significant first, as the frame-length input selects. After the last data bit it moves to `ST_STOP`. A high stop vote leads to `ST_IDLE_WAIT`. A low stop vote marks a framing error and leads to `ST_RECOVER`. `ST_RECOVER` waits for a high tick and then moves to `ST_IDLE_WAIT`. `ST_IDLE_WAIT` counts consecutive high ticks. If a low tick arrives first, it moves to `ST_START` as a new start. Once the idle count is reached, it returns to `ST_HUNT` and drops receiver-active.

The surrounding logic supplies the tick, which is one clock wide, and reads the outputs whenever receive-full pulses.

Top module: `mrx_receiver`

## Requirements
- R1: Each bit value is the majority of the line samples taken on tick slots 7, 8 and 9 of that bit. A single disagreeing sample does not change the received data.
- R2: If the three samples of the accepted start bit, of any data bit, or of the stop bit do not all agree, `noise_err` is 1 for that frame. Otherwise it is 0.
- R3: A low line that the start-bit vote rejects produces no receive-full strobe, and its samples do not set `noise_err`. The same holds for low glitches on an idle line. The receiver then goes back to hunting.
- R4: `noise_err` changes only in the cycle in which `rx_full` is 1. Noise seen partway through a frame does not show until that frame completes.
- R5: `rx_active` is 0 after reset. It rises on the tick that sees a possible start bit and stays 1 through the frame, including when `rx_full` pulses. It falls after `IDLE_TICKS` consecutive high ticks (default 32), or when a start is rejected. A start that arrives during the idle count keeps it at 1.
- R6: If the stop-bit vote is 0, `frame_err` is 1 together with `rx_full`. Otherwise `frame_err` is 0.
- R7: If every data bit is 0 and the stop-bit vote is 0, `break_det` is 1 together with `rx_full`, and `rx_data` is 0. `break_det` is never 1 without `frame_err`.
- R8: `wide_frame` is sampled when a start is seen. 1 selects 9 data bits. 0 selects 8 data bits, and `rx_data[8]` then reads 0. Data arrives least significant bit first.
- R9: `rx_full` pulses for exactly one clock per received frame. `rx_data` holds its value until the next pulse.
- R10: After a low stop bit, a line that stays low produces no further frames. Reception resumes normally once the line has gone high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Asynchronous serial input, high when idle |
| tick16 | input | 1 | One-clock strobe at 16x the bit rate |
| wide_frame | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| rx_data | output | MAX_BITS (9) | Last received character |
| rx_full | output | 1 | One-clock strobe when a character is delivered |
| noise_err | output | 1 | Sample disagreement seen in the last frame |
| frame_err | output | 1 | Stop bit of the last frame voted low |
| break_det | output | 1 | Last frame was all zeros with a low stop bit |
| rx_active | output | 1 | Receiver busy between start detection and idle line |

## Verification
The bench flips single samples on ticks 7, 8 and 9 of the start, data and stop bits. A design that votes on the wrong ticks corrupts the data. One that decides on one sample misses the noise flag. One that forgets to clear its noise accumulator at a new start reports noise on a clean frame. The bench also drives a one-tick idle glitch and a start that is rejected despite its noisy samples. A design that lets either one leak would show a stray frame or a false noise flag on the next frame. It would also fail to drop the receiver-active output. A break followed by a line held low checks that the framing path does not treat the low line as new start bits. Frames sent back to back, and a change between 8-bit and 9-bit frame length, check the bit counting and the idle-line count.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

    // Controller states of the receiver
    typedef enum logic [2:0] {
        ST_HUNT      = 3'd0,
        ST_START     = 3'd1,
        ST_DATA      = 3'd2,
        ST_STOP      = 3'd3,
        ST_RECOVER   = 3'd4,
        ST_IDLE_WAIT = 3'd5
    } rx_state_e;

    // Oversampling geometry
    localparam int unsigned OVERSAMPLE   = 16;
    localparam int unsigned SAMPLE_FIRST = 7;
    localparam int unsigned SAMPLE_COUNT = 3;
    localparam int unsigned EVAL_TICK    = SAMPLE_FIRST + SAMPLE_COUNT;
    localparam int unsigned PHASE_W      = $clog2(OVERSAMPLE);

endpackage

// File: rtl/mrx_sync.sv
module mrx_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= RESET_VAL;
                    else        chain_q[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= RESET_VAL;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/mrx_phase.sv
module mrx_phase
    import mrx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               restart,
    output logic [PHASE_W-1:0] phase
);

    logic [PHASE_W-1:0] cnt_q;

    // cnt_q holds the slot index of the last tick; restart marks slot 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (restart) cnt_q <= '0;
            else         cnt_q <= cnt_q + 1'b1;
        end
    end

    // slot index of the tick currently being presented
    assign phase = cnt_q + 1'b1;

endmodule

// File: rtl/mrx_vote.sv
module mrx_vote #(
    parameter int unsigned TAPS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic bit_in,
    output logic maj,
    output logic disagree
);

    localparam int unsigned CNT_W = $clog2(TAPS + 1);

    logic [TAPS-1:0] samp_q;
    logic [CNT_W-1:0] ones;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        samp_q <= '1;
        else if (shift_en) samp_q <= {samp_q[TAPS-2:0], bit_in};
    end

    always_comb begin
        ones = '0;
        for (int i = 0; i < TAPS; i++) begin
            ones = ones + CNT_W'(samp_q[i]);
        end
    end

    assign maj      = (ones > CNT_W'(TAPS / 2));
    assign disagree = (ones != '0) && (ones != CNT_W'(TAPS));

endmodule

// File: rtl/mrx_receiver.sv
module mrx_receiver
    import mrx_pkg::*;
#(
    parameter int unsigned MAX_BITS    = 9,
    parameter int unsigned IDLE_TICKS  = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_line,
    input  logic                tick16,
    input  logic                wide_frame,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_full,
    output logic                noise_err,
    output logic                frame_err,
    output logic                break_det,
    output logic                rx_active
);

    localparam int unsigned IDX_W  = $clog2(MAX_BITS + 1);
    localparam int unsigned IDLE_W = $clog2(IDLE_TICKS + 1);

    rx_state_e            state_q, state_d;
    logic                 line_s;
    logic [PHASE_W-1:0]   phase;
    logic                 maj, disagree;
    logic [MAX_BITS-1:0]  data_acc;
    logic [IDX_W-1:0]     bit_idx;
    logic [IDLE_W-1:0]    idle_cnt;
    logic                 noise_acc;
    logic                 long_q;

    logic                 hunting, in_bit, start_seen;
    logic                 samp_en, eval, last_bit, idle_done;

    mrx_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_line),
        .q     (line_s)
    );

    assign hunting    = (state_q == ST_HUNT) || (state_q == ST_IDLE_WAIT);
    assign start_seen = tick16 && hunting && !line_s;
    assign in_bit     = (state_q == ST_START) || (state_q == ST_DATA) || (state_q == ST_STOP);

    mrx_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16),
        .restart (start_seen),
        .phase   (phase)
    );

    assign samp_en = tick16 && in_bit
                   && (phase >= PHASE_W'(SAMPLE_FIRST))
                   && (phase <  PHASE_W'(EVAL_TICK));
    assign eval    = tick16 && in_bit && (phase == PHASE_W'(EVAL_TICK));

    mrx_vote #(
        .TAPS (SAMPLE_COUNT)
    ) u_vote (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (samp_en),
        .bit_in   (line_s),
        .maj      (maj),
        .disagree (disagree)
    );

    assign last_bit  = long_q ? (bit_idx == IDX_W'(MAX_BITS - 1))
                              : (bit_idx == IDX_W'(MAX_BITS - 2));
    assign idle_done = tick16 && line_s && (state_q == ST_IDLE_WAIT)
                     && (idle_cnt == IDLE_W'(IDLE_TICKS - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (start_seen) state_d = ST_START;
            end
            ST_START: begin
                if (eval) state_d = maj ? ST_HUNT : ST_DATA;
            end
            ST_DATA: begin
                if (eval && last_bit) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (eval) state_d = maj ? ST_IDLE_WAIT : ST_RECOVER;
            end
            ST_RECOVER: begin
                if (tick16 && line_s) state_d = ST_IDLE_WAIT;
            end
            ST_IDLE_WAIT: begin
                if (start_seen)     state_d = ST_START;
                else if (idle_done) state_d = ST_HUNT;
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data   <= '0;
            rx_full   <= 1'b0;
            noise_err <= 1'b0;
            frame_err <= 1'b0;
            break_det <= 1'b0;
            rx_active <= 1'b0;
            data_acc  <= '0;
            bit_idx   <= '0;
            idle_cnt  <= '0;
            noise_acc <= 1'b0;
            long_q    <= 1'b0;
        end else begin
            rx_full <= 1'b0;
            unique case (state_q)
                ST_HUNT, ST_IDLE_WAIT: begin
                    if (start_seen) begin
                        rx_active <= 1'b1;
                        noise_acc <= 1'b0;
                        data_acc  <= '0;
                        bit_idx   <= '0;
                        long_q    <= wide_frame;
                    end else if (tick16 && (state_q == ST_IDLE_WAIT)) begin
                        idle_cnt <= idle_cnt + 1'b1;
                        if (idle_done) rx_active <= 1'b0;
                    end
                end
                ST_START: begin
                    if (eval) begin
                        if (maj) rx_active <= 1'b0;
                        else     noise_acc <= disagree;
                    end
                end
                ST_DATA: begin
                    if (eval) begin
                        for (int i = 0; i < MAX_BITS; i++) begin
                            if (bit_idx == IDX_W'(i)) data_acc[i] <= maj;
                        end
                        noise_acc <= noise_acc | disagree;
                        bit_idx   <= bit_idx + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (eval) begin
                        rx_full   <= 1'b1;
                        rx_data   <= data_acc;
                        noise_err <= noise_acc | disagree;
                        frame_err <= !maj;
                        break_det <= !maj && (data_acc == '0);
                        idle_cnt  <= '0;
                    end
                end
                ST_RECOVER: begin
                    idle_cnt <= '0;
                end
                default: begin
                    rx_active <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/mrx_receiver_chk.sv
module mrx_receiver_chk #(
    parameter int unsigned MAX_BITS = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic [MAX_BITS-1:0] rx_data,
    input logic                rx_full,
    input logic                noise_err,
    input logic                frame_err,
    input logic                break_det,
    input logic                rx_active,
    input logic                long_q
);

    p_full_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |=> !rx_full);

    p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_full |-> $stable(rx_data));

    p_noise_at_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_full |-> $stable(noise_err));

    p_active_at_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> rx_active);

    p_break_framed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        break_det |-> frame_err);

    p_break_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && break_det) |-> (rx_data == '0));

    p_narrow_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !long_q) |-> (rx_data[MAX_BITS-1] == 1'b0));

endmodule

bind mrx_receiver mrx_receiver_chk #(.MAX_BITS(MAX_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_data   (rx_data),
    .rx_full   (rx_full),
    .noise_err (noise_err),
    .frame_err (frame_err),
    .break_det (break_det),
    .rx_active (rx_active),
    .long_q    (long_q)
);

// File: tb/mrx_receiver_tb.sv
module mrx_receiver_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int WATCHDOG   = 150000;

    typedef struct packed {
        logic [8:0] d;
        logic       n;
        logic       f;
        logic       b;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       tick16;
    logic       wide_frame = 1'b0;
    logic [8:0] rx_data;
    logic       rx_full, noise_err, frame_err, break_det, rx_active;

    int   tests_run = 0;
    int   tests_failed = 0;
    bit   done = 1'b0;
    int   div_cnt;
    logic prev_full;
    exp_t exp_q[$];
    exp_t cur;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= 0;
            tick16  <= 1'b0;
        end else begin
            div_cnt <= (div_cnt == TICK_DIV-1) ? 0 : div_cnt + 1;
            tick16  <= (div_cnt == TICK_DIV-1);
        end
    end

    mrx_receiver u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_line    (rx_line),
        .tick16     (tick16),
        .wide_frame (wide_frame),
        .rx_data    (rx_data),
        .rx_full    (rx_full),
        .noise_err  (noise_err),
        .frame_err  (frame_err),
        .break_det  (break_det),
        .rx_active  (rx_active)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops expected frames whenever the receiver delivers one
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_full && prev_full)
                check(1'b0, "R9", "receive-full longer than one cycle", 32'd1, 32'd0);
            if (rx_full) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3/R10", "unexpected frame", {23'd0, rx_data}, 32'd0);
                end else begin
                    cur = exp_q.pop_front();
                    check(rx_data == cur.d,   "R1/R8", "data",      {23'd0, rx_data}, {23'd0, cur.d});
                    check(noise_err == cur.n, "R2/R3", "noise",     {31'd0, noise_err}, {31'd0, cur.n});
                    check(frame_err == cur.f, "R6",    "framing",   {31'd0, frame_err}, {31'd0, cur.f});
                    check(break_det == cur.b, "R7",    "break",     {31'd0, break_det}, {31'd0, cur.b});
                end
            end
            prev_full <= rx_full;
        end else begin
            prev_full <= 1'b0;
        end
    end

    // One tick slot: line set right after a tick cycle, held for one tick period
    task automatic tick_drive(input logic v);
        rx_line = v;
        repeat (TICK_DIV) @(negedge clk);
    endtask

    task automatic bit_slot(input logic v, input int flip);
        for (int t = 0; t < 16; t++) tick_drive((t == flip) ? ~v : v);
    endtask

    task automatic idle_slots(input int n);
        for (int i = 0; i < n; i++) bit_slot(1'b1, -1);
    endtask

    // slot 0 = start, 1..nb = data, nb+1 = stop; noisy_slot/noisy_tick flip one sample
    task automatic send_frame(input logic [8:0] d, input bit wide, input logic stop_v,
                              input int noisy_slot, input int noisy_tick,
                              input bit chk_mid);
        int   nb;
        exp_t e;
        logic [8:0] m;
        nb = wide ? 9 : 8;
        m  = wide ? d : {1'b0, d[7:0]};
        e.d = m;
        e.n = (noisy_slot >= 0) && (noisy_tick >= 7) && (noisy_tick <= 9);
        e.f = !stop_v;
        e.b = !stop_v && (m == 9'd0);
        exp_q.push_back(e);
        wide_frame = wide;
        for (int s = 0; s <= nb + 1; s++) begin
            logic v;
            if (s == 0)            v = 1'b0;
            else if (s == nb + 1)  v = stop_v;
            else                   v = m[s-1];
            bit_slot(v, (s == noisy_slot) ? noisy_tick : -1);
            if (chk_mid && s == 1) begin
                check(rx_active == 1'b1, "R5", "active after start", {31'd0, rx_active}, 32'd1);
                check(noise_err == 1'b0, "R4", "noise shown mid-frame", {31'd0, noise_err}, 32'd0);
            end
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            tests_failed++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    initial begin
        rx_line    = 1'b1;
        wide_frame = 1'b0;
        rst_n      = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R5, R9)
        check(rx_active == 1'b0, "R5", "reset active", {31'd0, rx_active}, 32'd0);
        check(rx_full == 1'b0,   "R9", "reset full",   {31'd0, rx_full}, 32'd0);
        check(rx_data == 9'd0,   "R9", "reset data",   {23'd0, rx_data}, 32'd0);
        check({noise_err, frame_err, break_det} == 3'b000, "R2", "reset flags",
              {29'd0, noise_err, frame_err, break_det}, 32'd0);

        @(negedge clk iff tick16);
        idle_slots(2);

        // R1/R5: clean frame, active rise and late fall
        send_frame(9'h0A5, 1'b0, 1'b1, -1, -1, 1'b1);
        idle_slots(1);
        check(rx_active == 1'b1, "R5", "active before idle count", {31'd0, rx_active}, 32'd1);
        idle_slots(2);
        check(rx_active == 1'b0, "R5", "active after idle line", {31'd0, rx_active}, 32'd0);

        // R1/R2: one flipped sample on data bit 3, then on start (R4 mid-frame), then stop
        send_frame(9'h03C, 1'b0, 1'b1, 4, 8, 1'b0);
        idle_slots(3);
        send_frame(9'h011, 1'b0, 1'b1, -1, -1, 1'b0);
        idle_slots(1);
        send_frame(9'h05A, 1'b0, 1'b1, 0, 7, 1'b1);
        idle_slots(1);
        send_frame(9'h0E7, 1'b0, 1'b1, 9, 9, 1'b0);
        idle_slots(1);
        // flip outside the sample window: no noise (R2)
        send_frame(9'h066, 1'b0, 1'b1, 2, 3, 1'b0);
        idle_slots(3);

        // R3: one-tick glitch on idle line, then a noisy but rejected start
        tick_drive(1'b0);
        idle_slots(1);
        check(rx_active == 1'b0, "R3", "active after glitch", {31'd0, rx_active}, 32'd0);
        for (int t = 0; t < 8; t++) tick_drive(1'b0);
        idle_slots(2);
        check(rx_active == 1'b0, "R3", "active after rejected start", {31'd0, rx_active}, 32'd0);
        send_frame(9'h081, 1'b0, 1'b1, -1, -1, 1'b0);
        idle_slots(1);

        // R6: framing error, nonzero data
        send_frame(9'h03C, 1'b0, 1'b0, -1, -1, 1'b0);
        idle_slots(3);

        // R7/R10: break, line held low, then recovery
        send_frame(9'h000, 1'b0, 1'b0, -1, -1, 1'b0);
        bit_slot(1'b0, -1);
        bit_slot(1'b0, -1);
        bit_slot(1'b0, -1);
        check(rx_active == 1'b1, "R10", "active while line low", {31'd0, rx_active}, 32'd1);
        idle_slots(3);
        send_frame(9'h07E, 1'b0, 1'b1, -1, -1, 1'b0);
        idle_slots(1);

        // R8: 9-bit frames and return to 8-bit; back-to-back frames (R5)
        send_frame(9'h1A5, 1'b1, 1'b1, -1, -1, 1'b0);
        send_frame(9'h100, 1'b1, 1'b1, -1, -1, 1'b0);
        check(rx_active == 1'b1, "R5", "active between back-to-back", {31'd0, rx_active}, 32'd1);
        idle_slots(1);
        send_frame(9'h1C3, 1'b0, 1'b1, -1, -1, 1'b0);
        idle_slots(4);

        // R9: data held long after delivery
        check(rx_data == 9'h0C3, "R9", "data held", {23'd0, rx_data}, 32'h0C3);
        check(exp_q.size() == 0, "R9", "frames not delivered", exp_q.size(), 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule